// File: doc/BRIEF.md
# Three-Level Carrier PWM Modulator

This block turns three signed, normalized phase references into gate commands for the four switches of each leg of a three-phase, three-level inverter with a clamped mid-point. A selectable common-mode offset is added to all three references. The offset can be zero, min/max centering of the raw references, or a two-part centering in which each reference is split into a sign-derived pivot and a residual and each part is centered on its own. The modified references are compared against a symmetric up/down carrier. Each leg then switches only its upper or its lower outer device, depending on the sign of its modified reference.

References are Q-format fractions of the DC-link voltage, with full scale 1.0 = 2^(REF_W-2). New references and a new mode are sampled only at the carrier peak, so a duty never changes part-way through a carrier period. Gate outputs are registered.

Top module: `npc3_pwm_mod`

## Requirements
- R1: While `rst_n` is low, every leg is held in the neutral state: both outer gates are low and both inner gates are high.
- R2: The carrier counts 0 up to P-1 and back down to 0, holding each end for two cycles, so one period is 2P cycles with P = 2^CAR_W. For a modified reference u >= 0, the leg threshold is t = floor(2|u|·2^FRAC / 2^FRAC >> (FRAC-CAR_W)), that is (2|u|) >> (FRAC-CAR_W) in raw units. The upper outer gate is high for exactly 2t cycles of every period as one contiguous run, and the lower outer gate stays low.
- R3: For u < 0 the mirror applies. The lower outer gate is high for 2t cycles per period, and the upper outer gate stays low. The two outer gates are never high together.
- R4: The inner lower gate is always the complement of the upper outer gate, and the inner upper gate is always the complement of the lower outer gate. A modified reference of exactly zero counts as positive.
- R5: Mode code 2'b00 (and the unused code 2'b11) applies a common-mode offset of zero.
- R6: Mode code 2'b01 applies offset = -floor((max+min)/2) over the three raw references.
- R7: Mode code 2'b10 forms pivots from the count of negative references. With one negative, positive phases get +floor(ONE/6) and the negative phase gets -floor(ONE/3). With two negatives, positive phases get +floor(ONE/3) and negative phases get -floor(ONE/6). With zero or three negatives, every pivot is 0. Residual = reference - pivot. The offset is -floor((max+min)/2) over the pivots plus -floor((max+min)/2) over the residuals.
- R8: Each modified reference is limited to the range [-ONE/2, +ONE/2] before comparison.
- R9: References and mode are sampled only at the carrier peak. A change made at any other time leaves the gate run in progress unchanged, and takes effect from the first run after the next peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Offset mode: 00 zero, 01 centered, 10 pivot-split centered, 11 as 00 |
| ref_a_i | input | REF_W | Phase A reference, signed, ONE = 2^(REF_W-2) |
| ref_b_i | input | REF_W | Phase B reference, signed |
| ref_c_i | input | REF_W | Phase C reference, signed |
| out_hi_o | output | 3 | Upper outer gate per leg (bit 0 = A) |
| in_hi_o | output | 3 | Upper inner (clamp) gate per leg |
| in_lo_o | output | 3 | Lower inner (clamp) gate per leg |
| out_lo_o | output | 3 | Lower outer gate per leg |

## Verification
Two functions of the block can fall in the same cycle: a leg is in the middle of a gate pulse, and a reference or mode change arrives. The bench provokes this by changing the reference, and in a second case the mode, on the very first high cycle of a pulse. It then judges that the pulse still has the length set by the old threshold and that the following pulse has the length set by the new one. Steady-state duties under all four mode codes, the clamp and the zero-reference case are measured as gate-high counts over a whole carrier period, and compared with an offset model written from the requirements.

// File: rtl/npc3_pwm_pkg.sv
package npc3_pwm_pkg;
   typedef enum logic [1:0] {
      MODE_SINE   = 2'b00,
      MODE_CENTER = 2'b01,
      MODE_OPTIM  = 2'b10,
      MODE_RSVD   = 2'b11
   } cm_mode_e;
endpackage

// File: rtl/npc3_carrier.sv
module npc3_carrier #(
   parameter int CAR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CAR_W-1:0] cnt_o,
   output logic             peak_o
);
   localparam logic [CAR_W-1:0] TOP = {CAR_W{1'b1}};

   logic dir_up;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_o  <= '0;
         dir_up <= 1'b1;
      end else if (dir_up) begin
         if (cnt_o == TOP) dir_up <= 1'b0;
         else              cnt_o  <= cnt_o + 1'b1;
      end else begin
         if (cnt_o == '0)  dir_up <= 1'b1;
         else              cnt_o  <= cnt_o - 1'b1;
      end
   end

   assign peak_o = dir_up && (cnt_o == TOP);

   // R2
   carrier_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_up && cnt_o != TOP) |=> (cnt_o == $past(cnt_o) + 1'b1));
   // R9
   peak_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      peak_o |=> (!dir_up && cnt_o == TOP));
endmodule

// File: rtl/npc3_cm_offset.sv
module npc3_cm_offset
   import npc3_pwm_pkg::*;
#(
   parameter int REF_W = 16,
   parameter int FRAC  = 14,
   parameter int W     = 19
) (
   input  cm_mode_e                mode_i,
   input  logic signed [REF_W-1:0] ref_i [3],
   output logic signed [W-1:0]     cm_o
);
   localparam int ONE = 1 << FRAC;
   localparam logic signed [W-1:0] SIXTH = W'(ONE / 6);
   localparam logic signed [W-1:0] THIRD = W'(ONE / 3);

   logic [2:0]           neg;
   logic [1:0]           n_neg;
   logic signed [W-1:0]  ext [3];
   logic signed [W-1:0]  piv [3];
   logic signed [W-1:0]  res [3];
   logic signed [W-1:0]  psum;

   function automatic logic signed [W-1:0] max3(input logic signed [W-1:0] a,
                                                 input logic signed [W-1:0] b,
                                                 input logic signed [W-1:0] c);
      logic signed [W-1:0] m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic logic signed [W-1:0] min3(input logic signed [W-1:0] a,
                                                 input logic signed [W-1:0] b,
                                                 input logic signed [W-1:0] c);
      logic signed [W-1:0] m;
      m = (a < b) ? a : b;
      return (m < c) ? m : c;
   endfunction

   function automatic logic signed [W-1:0] mid(input logic signed [W-1:0] hi,
                                                input logic signed [W-1:0] lo);
      logic signed [W-1:0] s;
      s = hi + lo;
      return s >>> 1;
   endfunction

   for (genvar i = 0; i < 3; i++) begin : g_ph
      assign neg[i] = ref_i[i][REF_W-1];
      assign ext[i] = {{(W-REF_W){ref_i[i][REF_W-1]}}, ref_i[i]};
      always_comb begin
         case ({n_neg, neg[i]})
            3'b010:  piv[i] = SIXTH;
            3'b011:  piv[i] = -THIRD;
            3'b100:  piv[i] = THIRD;
            3'b101:  piv[i] = -SIXTH;
            default: piv[i] = '0;
         endcase
      end
      assign res[i] = ext[i] - piv[i];
   end

   assign n_neg = 2'($countones(neg));
   assign psum  = piv[0] + piv[1] + piv[2];

   always_comb begin
      case (mode_i)
         MODE_CENTER: cm_o = -mid(max3(ext[0], ext[1], ext[2]),
                                  min3(ext[0], ext[1], ext[2]));
         MODE_OPTIM:  cm_o = -mid(max3(piv[0], piv[1], piv[2]),
                                  min3(piv[0], piv[1], piv[2]))
                             - mid(max3(res[0], res[1], res[2]),
                                   min3(res[0], res[1], res[2]));
         default:     cm_o = '0;
      endcase
   end

   // R7
   always_comb begin
      pivot_bal_chk: assert (psum >= -1 && psum <= 1);
   end
endmodule

// File: rtl/npc3_leg.sv
module npc3_leg #(
   parameter int CAR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CAR_W-1:0] cnt_i,
   input  logic [CAR_W:0]   thr_i,
   input  logic             neg_i,
   output logic             out_hi_o,
   output logic             in_hi_o,
   output logic             in_lo_o,
   output logic             out_lo_o
);
   logic pwm;

   assign pwm = thr_i > {1'b0, cnt_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_hi_o <= 1'b0;
         in_hi_o  <= 1'b1;
         in_lo_o  <= 1'b1;
         out_lo_o <= 1'b0;
      end else if (!neg_i) begin
         out_hi_o <= pwm;
         in_hi_o  <= 1'b1;
         in_lo_o  <= !pwm;
         out_lo_o <= 1'b0;
      end else begin
         out_hi_o <= 1'b0;
         in_hi_o  <= !pwm;
         in_lo_o  <= 1'b1;
         out_lo_o <= pwm;
      end
   end

   // R4
   upper_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_hi_o != in_lo_o);
   // R4
   lower_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_lo_o != in_hi_o);
   // R3
   outer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_hi_o && out_lo_o));
endmodule

// File: rtl/npc3_pwm_mod.sv
module npc3_pwm_mod
   import npc3_pwm_pkg::*;
#(
   parameter int REF_W = 16,
   parameter int CAR_W = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              mode_i,
   input  logic signed [REF_W-1:0] ref_a_i,
   input  logic signed [REF_W-1:0] ref_b_i,
   input  logic signed [REF_W-1:0] ref_c_i,
   output logic [2:0]              out_hi_o,
   output logic [2:0]              in_hi_o,
   output logic [2:0]              in_lo_o,
   output logic [2:0]              out_lo_o
);
   localparam int FRAC = REF_W - 2;
   localparam int W    = REF_W + 3;
   localparam int HALF = 1 << (FRAC - 1);
   localparam int SH   = FRAC - CAR_W;
   localparam int P    = 1 << CAR_W;
   localparam logic signed [W-1:0] POS_LIM = W'(HALF);
   localparam logic signed [W-1:0] NEG_LIM = -POS_LIM;

   initial begin
      param_chk: assert (REF_W >= 6 && CAR_W >= 2 && CAR_W <= FRAC);
   end

   logic [CAR_W-1:0]        cnt;
   logic                    peak;
   logic signed [REF_W-1:0] ref_q [3];
   cm_mode_e                mode_q;
   logic signed [W-1:0]     cm;

   npc3_carrier #(.CAR_W(CAR_W)) u_carrier (
      .clk(clk), .rst_n(rst_n), .cnt_o(cnt), .peak_o(peak));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q[0] <= '0;
         ref_q[1] <= '0;
         ref_q[2] <= '0;
         mode_q   <= MODE_SINE;
      end else if (peak) begin
         ref_q[0] <= ref_a_i;
         ref_q[1] <= ref_b_i;
         ref_q[2] <= ref_c_i;
         mode_q   <= cm_mode_e'(mode_i);
      end
   end

   npc3_cm_offset #(.REF_W(REF_W), .FRAC(FRAC), .W(W)) u_offset (
      .mode_i(mode_q), .ref_i(ref_q), .cm_o(cm));

   for (genvar i = 0; i < 3; i++) begin : g_leg
      logic signed [W-1:0] u_raw, u_lim;
      logic [W-1:0]        mag;
      logic [CAR_W:0]      thr;

      assign u_raw = {{(W-REF_W){ref_q[i][REF_W-1]}}, ref_q[i]} + cm;
      assign u_lim = (u_raw > POS_LIM) ? POS_LIM :
                     (u_raw < NEG_LIM) ? NEG_LIM : u_raw;
      assign mag   = u_lim[W-1] ? W'(-u_lim) : W'(u_lim);
      assign thr   = (CAR_W+1)'((mag << 1) >> SH);

      npc3_leg #(.CAR_W(CAR_W)) u_leg (
         .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .thr_i(thr),
         .neg_i(u_lim[W-1]),
         .out_hi_o(out_hi_o[i]), .in_hi_o(in_hi_o[i]),
         .in_lo_o(in_lo_o[i]), .out_lo_o(out_lo_o[i]));

      // R8
      thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         thr <= (CAR_W+1)'(P));
   end

   // R9
   hold_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !peak |=> ($stable(ref_q[0]) && $stable(ref_q[1]) &&
                 $stable(ref_q[2]) && $stable(mode_q)));
endmodule

// File: tb/npc3_pwm_mod_bench.sv
module npc3_pwm_mod_bench;
   localparam int REF_W = 16;
   localparam int CAR_W = 6;
   localparam int FRAC  = REF_W - 2;
   localparam int ONE   = 1 << FRAC;
   localparam int HALF  = ONE / 2;
   localparam int SH    = FRAC - CAR_W;
   localparam int P     = 1 << CAR_W;
   localparam int NV    = 9;

   // columns: mode, ref A, ref B, ref C, requirement number exercised
   localparam int VEC [NV][5] = '{
      '{0,   4000, -2000, -2000, 5},   // R5 zero offset
      '{0,      0,  6000, -6000, 4},   // R4 zero reference counts positive
      '{1,   7000, -3500, -3500, 6},   // R6 centered
      '{1,   8000,  1000, -9000, 8},   // R8 centered, both limits hit
      '{2,   6000, -3000, -3000, 7},   // R7 two negatives
      '{2,   3000,  2000,  1000, 7},   // R7 no negatives, pivots zero
      '{2,  -5000,  4000,  1000, 7},   // R7 one negative
      '{3,   4000,  1000, -5000, 5},   // R5 unused code acts as zero offset
      '{0,  12000,-12000,     0, 8}    // R8 raw references past the limit
   };

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [1:0]              mode = 2'b00;
   logic signed [REF_W-1:0] ra = '0, rb = '0, rc = '0;
   logic [2:0]              out_hi, in_hi, in_lo, out_lo;
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   int c_oh[3], c_ih[3], c_il[3], c_ol[3];

   always #2.5 clk = ~clk;

   npc3_pwm_mod #(.REF_W(REF_W), .CAR_W(CAR_W)) u_npc3_pwm_mod (
      .clk(clk), .rst_n(rst_n), .mode_i(mode),
      .ref_a_i(ra), .ref_b_i(rb), .ref_c_i(rc),
      .out_hi_o(out_hi), .in_hi_o(in_hi), .in_lo_o(in_lo), .out_lo_o(out_lo));

   task automatic chk(input int got, input int exp, input string what);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", what, got, exp);
      end
   endtask

   function automatic int mx3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic int mn3(input int a, input int b, input int c);
      int m;
      m = (a < b) ? a : b;
      return (m < c) ? m : c;
   endfunction

   // threshold of one phase, negative when the modified reference is negative
   function automatic int model_thr(input int md, input int a, input int b,
                                    input int c, input int ph);
      int r[3], p[3], q[3];
      int nn, cm, u, mag;
      r = '{a, b, c};
      nn = 0;
      for (int i = 0; i < 3; i++) if (r[i] < 0) nn++;
      for (int i = 0; i < 3; i++) begin
         if (nn == 1)      p[i] = (r[i] < 0) ? -(ONE / 3) : ONE / 6;
         else if (nn == 2) p[i] = (r[i] < 0) ? -(ONE / 6) : ONE / 3;
         else              p[i] = 0;
         q[i] = r[i] - p[i];
      end
      case (md)
         1:       cm = -((mx3(r[0], r[1], r[2]) + mn3(r[0], r[1], r[2])) >>> 1);
         2:       cm = -((mx3(p[0], p[1], p[2]) + mn3(p[0], p[1], p[2])) >>> 1)
                       - ((mx3(q[0], q[1], q[2]) + mn3(q[0], q[1], q[2])) >>> 1);
         default: cm = 0;
      endcase
      u = r[ph] + cm;
      if (u > HALF)  u = HALF;
      if (u < -HALF) u = -HALF;
      mag = (u < 0) ? -u : u;
      return (u < 0) ? -((mag * 2) >>> SH) : ((mag * 2) >>> SH);
   endfunction

   task automatic count_window();
      for (int i = 0; i < 3; i++) begin
         c_oh[i] = 0; c_ih[i] = 0; c_il[i] = 0; c_ol[i] = 0;
      end
      for (int k = 0; k < 2 * P; k++) begin
         @(negedge clk);
         for (int i = 0; i < 3; i++) begin
            c_oh[i] += int'(out_hi[i]);
            c_ih[i] += int'(in_hi[i]);
            c_il[i] += int'(in_lo[i]);
            c_ol[i] += int'(out_lo[i]);
         end
      end
   endtask

   // wait for the first high cycle of out_hi[0]; returns 0 if none appears
   task automatic wait_rise(output bit seen);
      bit prev;
      seen = 1'b0;
      prev = out_hi[0];
      for (int k = 0; k < 4 * P && !seen; k++) begin
         @(negedge clk);
         if (!prev && out_hi[0]) seen = 1'b1;
         prev = out_hi[0];
      end
   endtask

   task automatic run_len(output int len);
      len = 1;
      for (int k = 0; k < 4 * P; k++) begin
         @(negedge clk);
         if (!out_hi[0]) break;
         len++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int e, len;
      bit seen;
      // R1 neutral state under reset
      repeat (3) @(negedge clk);
      chk(int'(out_hi), 0, "R1 outer upper in reset");
      chk(int'(out_lo), 0, "R1 outer lower in reset");
      chk(int'(in_hi), 7, "R1 inner upper in reset");
      chk(int'(in_lo), 7, "R1 inner lower in reset");
      rst_n = 1'b1;

      // steady-state duty vectors (R2 R3 R4 and the mode requirements)
      for (int v = 0; v < NV; v++) begin
         mode = 2'(VEC[v][0]);
         ra = REF_W'(VEC[v][1]);
         rb = REF_W'(VEC[v][2]);
         rc = REF_W'(VEC[v][3]);
         repeat (4 * P + 4) @(negedge clk);
         count_window();
         for (int i = 0; i < 3; i++) begin
            e = model_thr(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], i);
            chk(c_oh[i], (e >= 0) ? 2 * e : 0,
                $sformatf("R2 vec %0d (R%0d) leg %0d outer upper", v, VEC[v][4], i));
            chk(c_ol[i], (e < 0) ? -2 * e : 0,
                $sformatf("R3 vec %0d (R%0d) leg %0d outer lower", v, VEC[v][4], i));
            chk(c_il[i], 2 * P - c_oh[i],
                $sformatf("R4 vec %0d leg %0d inner lower", v, i));
            chk(c_ih[i], 2 * P - c_ol[i],
                $sformatf("R4 vec %0d leg %0d inner upper", v, i));
         end
      end

      // R9 reference change on the first high cycle of a pulse
      mode = 2'b00; ra = 16'sd4000; rb = '0; rc = '0;
      repeat (4 * P + 4) @(negedge clk);
      wait_rise(seen);
      chk(int'(seen), 1, "R9 pulse found before reference change");
      ra = '0;
      run_len(len);
      chk(len, 2 * model_thr(0, 4000, 0, 0, 0), "R9 pulse length kept after reference change");
      count_window();
      chk(c_oh[0], 0, "R9 new zero reference applied after peak");

      // R9 mode change on the first high cycle of a pulse
      mode = 2'b00; ra = 16'sd7000; rb = -16'sd3500; rc = -16'sd3500;
      repeat (4 * P + 4) @(negedge clk);
      wait_rise(seen);
      chk(int'(seen), 1, "R9 pulse found before mode change");
      mode = 2'b01;
      run_len(len);
      chk(len, 2 * model_thr(0, 7000, -3500, -3500, 0), "R9 pulse length kept after mode change");
      wait_rise(seen);
      run_len(len);
      chk(len, 2 * model_thr(1, 7000, -3500, -3500, 0), "R9 next pulse uses new mode (R6)");

      // R1 reset reasserted while switching
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(int'(out_hi | out_lo), 0, "R1 outer gates after reset reassert");
      chk(int'(in_hi & in_lo), 7, "R1 inner gates after reset reassert");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule